// File: doc/BRIEF.md
# Dual-Clock FIFO with Partial Reset and Rewind

This block is a single-direction first-in first-out buffer whose write side and read side run on unrelated clocks. Words enter on the write clock when the write enable is high and the buffer is not full. They leave through a registered output on the read clock when the read enable is high and the buffer is not empty. The write and read positions cross between the two clock domains as Gray-coded values through two-stage synchronisers. An empty flag is produced on the read side and a full flag on the write side.

Three reset-like actions are provided. An active-low master reset clears everything asynchronously. One shared active-low control pin does one of two jobs, chosen by a mode input. With the mode low it performs a partial reset, which empties the buffer and zeroes the output register. With the mode high it performs a rewind, which moves only the read position back to storage location zero. After a rewind, words that were already read can be read a second time. Each clock domain synchronises the control pin and the mode input before acting on them.

Top module: `rewind_fifo`

## Requirements
- R1: While `mrstN` is low, and after it is released, `empty` is 1, `full` is 0 and `rdData` is all zeros.
- R2: Words are read out in the order they were written. `rdData` takes the next word on the `rdClk` rising edge that accepts a read, and holds its value on every other edge.
- R3: After DEPTH (default 16) accepted writes with no reads, `full` is 1. Writes attempted while `full` is 1 are dropped and leave the write position unchanged, so a later read-out returns only the first DEPTH words.
- R4: A read attempted while `empty` is 1 is dropped. `rdData` keeps its value and the read position is unchanged, so the next word written is the next word read.
- R5: With `rtMode` low, holding `ctlN` low for at least four edges of each clock performs a partial reset. Afterwards `empty` is 1, `full` is 0, `rdData` is zero and all stored words are discarded.
- R6: With `rtMode` high, holding `ctlN` low performs a rewind. The read position returns to location 0, while `rdData` and the write position are kept. The words from location 0 onward are readable again, followed by any new writes.
- R7: After a write into an empty buffer, `empty` falls within four `rdClk` rising edges.
- R8: Each position crosses clock domains as a Gray code that changes by at most one bit per clock edge, except when a reset or rewind clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wrClk | input | 1 | Write-side clock |
| wrEn | input | 1 | Write request, sampled on wrClk rising edge |
| wrData | input | DATA_W (36) | Word to store |
| full | output | 1 | Buffer holds DEPTH words (write domain) |
| rdClk | input | 1 | Read-side clock |
| rdEn | input | 1 | Read request, sampled on rdClk rising edge |
| rdData | output | DATA_W (36) | Registered output word |
| empty | output | 1 | No unread word (read domain) |
| mrstN | input | 1 | Master reset, active low, asynchronous assert |
| ctlN | input | 1 | Shared partial-reset / rewind pin, active low |
| rtMode | input | 1 | 0: ctlN performs partial reset, 1: ctlN performs rewind |

## Verification
The embedded properties assume three things. First, `ctlN` is held low for several edges of both clocks, so both synchronisers see it. Second, `rtMode` does not change while `ctlN` is low. Third, a rewind is only requested when no more than DEPTH words have been written since the last reset, so that location 0 still holds the oldest kept word. The stimulus satisfies all three. It holds the control pin low for eight read-clock periods and changes the mode only after the pin has been high for four periods. It issues its one rewind after four writes that follow a partial reset. All inputs are driven on falling clock edges, and the two clocks run at different periods so that the synchronised flags are exercised with a moving phase.

// File: rtl/rewind_fifo_pkg.sv
package rewind_fifo_pkg;

  // Strobes from the control to the datapath
  typedef struct packed {
    logic memWrite;   // write-domain: store wrData at wrAddr
    logic outLoad;    // read-domain: load output register from rdAddr
    logic outClear;   // read-domain: zero output register
  } dpStrobe_t;

endpackage

// File: rtl/rewind_fifo_sync.sv
module rewind_fifo_sync #(
  parameter int WIDTH = 1,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             clear,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [WIDTH-1:0] stage [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : gStage
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          stage[s] <= RESET_VAL;
        end else if (clear) begin
          stage[s] <= RESET_VAL;
        end else if (s == 0) begin
          stage[s] <= din;
        end else begin
          stage[s] <= stage[(s == 0) ? 0 : s-1];
        end
      end
    end
  endgenerate

  assign dout = stage[STAGES-1];

endmodule

// File: rtl/rewind_fifo_ctrl.sv
module rewind_fifo_ctrl
  import rewind_fifo_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int ADDR_W = $clog2(DEPTH),
  localparam int PTR_W = ADDR_W + 1
) (
  input  logic              wrClk,
  input  logic              rdClk,
  input  logic              mrstN,
  input  logic              ctlN,
  input  logic              rtMode,
  input  logic              wrEn,
  input  logic              rdEn,
  output logic              full,
  output logic              empty,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [ADDR_W-1:0] rdAddr,
  output dpStrobe_t         strobe
);

  // Synchronised copies of {rtMode, ctlN}; idle value is mode 0, pin high
  logic [1:0] wrCtl, rdCtl;
  logic       wrPartial, rdPartial, rdRetx;

  rewind_fifo_sync #(.WIDTH(2), .STAGES(2), .RESET_VAL(2'b01)) uWrCtlSync (
    .clk(wrClk), .rstN(mrstN), .clear(1'b0), .din({rtMode, ctlN}), .dout(wrCtl)
  );
  rewind_fifo_sync #(.WIDTH(2), .STAGES(2), .RESET_VAL(2'b01)) uRdCtlSync (
    .clk(rdClk), .rstN(mrstN), .clear(1'b0), .din({rtMode, ctlN}), .dout(rdCtl)
  );

  assign wrPartial = !wrCtl[0] && !wrCtl[1];
  assign rdPartial = !rdCtl[0] && !rdCtl[1];
  assign rdRetx    = !rdCtl[0] &&  rdCtl[1];

  // ---------------- write domain ----------------
  logic [PTR_W-1:0] wrBin, wrGray, wrBinNext, wrGrayNext, rdGraySyncW;
  logic [PTR_W-1:0] rdBin, rdGray, rdBinNext, rdGrayNext, wrGraySyncR;
  logic             wrAccept, rdAccept;

  rewind_fifo_sync #(.WIDTH(PTR_W), .STAGES(2), .RESET_VAL('0)) uRdToWr (
    .clk(wrClk), .rstN(mrstN), .clear(wrPartial), .din(rdGray), .dout(rdGraySyncW)
  );

  assign full = (wrGray == {~rdGraySyncW[PTR_W-1:PTR_W-2], rdGraySyncW[PTR_W-3:0]});
  assign wrAccept   = wrEn && !full && !wrPartial;
  assign wrBinNext  = wrBin + PTR_W'(1);
  assign wrGrayNext = wrBinNext ^ (wrBinNext >> 1);

  always_ff @(posedge wrClk or negedge mrstN) begin
    if (!mrstN) begin
      wrBin  <= '0;
      wrGray <= '0;
    end else if (wrPartial) begin
      wrBin  <= '0;
      wrGray <= '0;
    end else if (wrAccept) begin
      wrBin  <= wrBinNext;
      wrGray <= wrGrayNext;
    end
  end

  // ---------------- read domain ----------------
  rewind_fifo_sync #(.WIDTH(PTR_W), .STAGES(2), .RESET_VAL('0)) uWrToRd (
    .clk(rdClk), .rstN(mrstN), .clear(rdPartial), .din(wrGray), .dout(wrGraySyncR)
  );

  assign empty      = (rdGray == wrGraySyncR);
  assign rdAccept   = rdEn && !empty && !rdPartial && !rdRetx;
  assign rdBinNext  = rdBin + PTR_W'(1);
  assign rdGrayNext = rdBinNext ^ (rdBinNext >> 1);

  always_ff @(posedge rdClk or negedge mrstN) begin
    if (!mrstN) begin
      rdBin  <= '0;
      rdGray <= '0;
    end else if (rdPartial || rdRetx) begin
      rdBin  <= '0;
      rdGray <= '0;
    end else if (rdAccept) begin
      rdBin  <= rdBinNext;
      rdGray <= rdGrayNext;
    end
  end

  assign wrAddr = wrBin[ADDR_W-1:0];
  assign rdAddr = rdBin[ADDR_W-1:0];

  always_comb begin
    strobe          = '0;
    strobe.memWrite = wrAccept;
    strobe.outLoad  = rdAccept;
    strobe.outClear = rdPartial;
  end

  // ---------------- assertions ----------------
  AST_NO_OVERFLOW: assert property (@(posedge wrClk) disable iff (!mrstN)
    (full && !wrPartial) |=> $stable(wrBin));                               // R3

  AST_NO_UNDERFLOW: assert property (@(posedge rdClk) disable iff (!mrstN)
    (empty && !rdPartial && !rdRetx) |=> $stable(rdBin));                   // R4

  AST_PARTIAL_CLEAR: assert property (@(posedge wrClk) disable iff (!mrstN)
    wrPartial |=> (wrBin == '0 && !full));                                  // R5

  AST_REWIND_READ: assert property (@(posedge rdClk) disable iff (!mrstN)
    rdRetx |=> (rdBin == '0));                                              // R6

  AST_GRAY_WR_STEP: assert property (@(posedge wrClk) disable iff (!mrstN)
    !wrPartial |=> ($countones(wrGray ^ $past(wrGray)) <= 1));              // R8

  AST_GRAY_RD_STEP: assert property (@(posedge rdClk) disable iff (!mrstN)
    (!rdPartial && !rdRetx) |=> ($countones(rdGray ^ $past(rdGray)) <= 1)); // R8

endmodule

// File: rtl/rewind_fifo_datapath.sv
module rewind_fifo_datapath
  import rewind_fifo_pkg::*;
#(
  parameter int DATA_W = 36,
  parameter int DEPTH = 16,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              wrClk,
  input  logic              rdClk,
  input  logic              mrstN,
  input  dpStrobe_t         strobe,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData
);

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge wrClk) begin
    if (strobe.memWrite) begin
      mem[wrAddr] <= wrData;
    end
  end

  always_ff @(posedge rdClk or negedge mrstN) begin
    if (!mrstN) begin
      rdData <= '0;
    end else if (strobe.outClear) begin
      rdData <= '0;
    end else if (strobe.outLoad) begin
      rdData <= mem[rdAddr];
    end
  end

  AST_OUT_HOLD: assert property (@(posedge rdClk) disable iff (!mrstN)
    (!strobe.outLoad && !strobe.outClear) |=> $stable(rdData));  // R2

endmodule

// File: rtl/rewind_fifo.sv
module rewind_fifo
  import rewind_fifo_pkg::*;
#(
  parameter int DATA_W = 36,
  parameter int DEPTH = 16
) (
  input  logic              wrClk,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  output logic              full,
  input  logic              rdClk,
  input  logic              rdEn,
  output logic [DATA_W-1:0] rdData,
  output logic              empty,
  input  logic              mrstN,
  input  logic              ctlN,
  input  logic              rtMode
);

  localparam int ADDR_W = $clog2(DEPTH);

  dpStrobe_t         strobe;
  logic [ADDR_W-1:0] wrAddr, rdAddr;

  rewind_fifo_ctrl #(.DEPTH(DEPTH)) uCtrl (
    .wrClk(wrClk), .rdClk(rdClk), .mrstN(mrstN), .ctlN(ctlN), .rtMode(rtMode),
    .wrEn(wrEn), .rdEn(rdEn), .full(full), .empty(empty),
    .wrAddr(wrAddr), .rdAddr(rdAddr), .strobe(strobe)
  );

  rewind_fifo_datapath #(.DATA_W(DATA_W), .DEPTH(DEPTH)) uData (
    .wrClk(wrClk), .rdClk(rdClk), .mrstN(mrstN), .strobe(strobe),
    .wrAddr(wrAddr), .rdAddr(rdAddr), .wrData(wrData), .rdData(rdData)
  );

  initial begin
    AST_DEPTH_POW2: assert (DEPTH >= 4 && (DEPTH & (DEPTH - 1)) == 0);  // R3
  end

endmodule

// File: tb/rewind_fifo_test.sv
module rewind_fifo_test;

  localparam int CLK_PERIOD = 10;
  localparam int RD_PERIOD  = CLK_PERIOD * 7 / 5;
  localparam int DATA_W = 36;
  localparam int DEPTH  = 16;
  localparam int NVEC   = 8;
  localparam logic [DATA_W-1:0] VEC [NVEC] = '{
    36'h000000001, 36'hFFFFFFFFF, 36'h123456789, 36'hA5A5A5A5A,
    36'h5A5A5A5A5, 36'h800000000, 36'h0DEADBEEF, 36'h7FFFFFFFE
  };

  logic wrClk = 0, rdClk = 0;
  logic wrEn = 0, rdEn = 0, mrstN = 0, ctlN = 1, rtMode = 0;
  logic [DATA_W-1:0] wrData = '0;
  logic [DATA_W-1:0] rdData;
  logic full, empty;
  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) wrClk = ~wrClk;
  always #(RD_PERIOD/2)  rdClk = ~rdClk;

  rewind_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) uut (
    .wrClk(wrClk), .wrEn(wrEn), .wrData(wrData), .full(full),
    .rdClk(rdClk), .rdEn(rdEn), .rdData(rdData), .empty(empty),
    .mrstN(mrstN), .ctlN(ctlN), .rtMode(rtMode)
  );

  task automatic checkVal(input string req, input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic writeWord(input logic [DATA_W-1:0] d);
    @(negedge wrClk); wrEn = 1; wrData = d;
    @(negedge wrClk); wrEn = 0;
  endtask

  task automatic readWord(output logic [DATA_W-1:0] d);
    @(negedge rdClk); rdEn = 1;
    @(negedge rdClk); rdEn = 0;
    d = rdData;
  endtask

  task automatic settle();
    repeat (6) @(negedge rdClk);
    repeat (6) @(negedge wrClk);
  endtask

  task automatic pulseCtl(input logic mode);
    @(negedge wrClk); rtMode = mode;
    repeat (4) @(negedge rdClk);
    ctlN = 0;
    repeat (8) @(negedge rdClk);
    ctlN = 1;
    repeat (4) @(negedge rdClk);
    rtMode = 0;
    settle();
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [DATA_W-1:0] got;
    int lat;

    // R1: master reset held well over four edges of each clock
    repeat (3) @(negedge rdClk);
    checkVal("R1 empty in reset", 36'(empty), 36'd1);
    checkVal("R1 full in reset", 36'(full), 36'd0);
    checkVal("R1 rdData in reset", rdData, '0);
    repeat (3) @(negedge rdClk);
    @(negedge wrClk); mrstN = 1;
    settle();
    checkVal("R1 empty after reset", 36'(empty), 36'd1);
    checkVal("R1 full after reset", 36'(full), 36'd0);
    checkVal("R1 rdData after reset", rdData, '0);

    // R2: vector table written then read back in order
    for (int i = 0; i < NVEC; i++) writeWord(VEC[i]);
    settle();
    checkVal("R2 not empty after writes", 36'(empty), 36'd0);
    for (int i = 0; i < NVEC; i++) begin
      readWord(got);
      checkVal($sformatf("R2 order word %0d", i), got, VEC[i]);
    end
    settle();
    checkVal("R2 empty after drain", 36'(empty), 36'd1);
    repeat (3) @(negedge rdClk);
    checkVal("R2 rdData holds without read", rdData, VEC[NVEC-1]);

    // R7: empty flag latency
    writeWord(36'h0000000C7);
    lat = 0;
    while (empty && lat < 8) begin
      @(negedge rdClk);
      lat++;
    end
    checks++;
    if (lat > 4) begin
      errors++;
      $display("FAIL R7 empty latency actual=%0d expected<=4", lat);
    end
    readWord(got);
    checkVal("R7 word read", got, 36'h0000000C7);
    settle();

    // R3: fill, overfill, drain
    for (int i = 0; i < DEPTH; i++) writeWord(36'(100 + i));
    checkVal("R3 full after DEPTH writes", 36'(full), 36'd1);
    for (int i = 0; i < 3; i++) writeWord(36'hBADBADBAD);
    settle();
    checkVal("R3 full held after overfill", 36'(full), 36'd1);
    for (int i = 0; i < DEPTH; i++) begin
      readWord(got);
      checkVal($sformatf("R3 word %0d", i), got, 36'(100 + i));
    end
    settle();
    checkVal("R3 overfill dropped, empty", 36'(empty), 36'd1);
    checkVal("R3 full cleared", 36'(full), 36'd0);

    // R4: read from empty ignored
    readWord(got);
    checkVal("R4 rdData unchanged on empty read", got, 36'(100 + DEPTH - 1));
    writeWord(36'h000000055);
    settle();
    readWord(got);
    checkVal("R4 read position unchanged", got, 36'h000000055);
    settle();

    // R5: partial reset
    writeWord(36'h1); writeWord(36'h2); writeWord(36'h3);
    settle();
    pulseCtl(1'b0);
    checkVal("R5 empty after partial", 36'(empty), 36'd1);
    checkVal("R5 full after partial", 36'(full), 36'd0);
    checkVal("R5 rdData zero after partial", rdData, '0);

    // R6: rewind
    for (int i = 0; i < 4; i++) writeWord(36'(36'hA0 + i));
    settle();
    readWord(got);
    checkVal("R5 old words discarded", got, 36'hA0);
    readWord(got);
    checkVal("R6 second word before rewind", got, 36'hA1);
    pulseCtl(1'b1);
    checkVal("R6 rdData kept by rewind", rdData, 36'hA1);
    checkVal("R6 not empty after rewind", 36'(empty), 36'd0);
    for (int i = 0; i < 4; i++) begin
      readWord(got);
      checkVal($sformatf("R6 reread word %0d", i), got, 36'(36'hA0 + i));
    end
    settle();
    checkVal("R6 empty after reread", 36'(empty), 36'd1);
    writeWord(36'h0000000E5);
    settle();
    readWord(got);
    checkVal("R6 write position kept", got, 36'h0000000E5);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule